// File: doc/BRIEF.md
# Binary Sign-Product 3x3 Window Dot Product

This block computes the dot product of one 3x3 window of a single input channel against a fixed 3x3 weight pattern. Both the activations and the weights are single bits that stand for +1 and -1. A product of two such values is +1 when the bits agree and -1 when they differ, so each tap is one XNOR gate and no multiplier is needed. The nine tap results are counted by a three-level adder tree. The count is then turned into a signed sum.

The block has two register stages. The first captures the nine tap products and the second captures the signed sum. Each stage has its own enable, so a shared controller can stall the product capture and the summation separately. A valid flag travels with the data through both stages. The weight pattern is a parameter, and the window size is set by a parameter that defaults to 3.

Top module: `xnor_window_dot`

## Requirements
- R1: A patch bit of 1 means +1 and a bit of 0 means -1, and the same holds for the weights. `dot_o` is a 5-bit two's-complement value equal to 2*m - 9, where m is the number of taps whose patch bit equals the weight bit.
- R2: Tap k, for k from 0 to 8, pairs `patch_i[k]` with bit k of `W_PATTERN`. Inverting any single patch bit of an all-matching patch lowers the result from +9 to +7.
- R3: With both enables held high, a patch presented before rising edge n appears on `dot_o` after rising edge n+1. A new patch may be presented on every cycle.
- R4: While `mul_en_i` is low, the product stage keeps its contents. The patch and valid inputs presented in those cycles never reach `dot_o`, and the sum stage goes on producing the previously captured patch's result.
- R5: While `sum_en_i` is low, `dot_o` and `dot_vld_o` keep their values. When the enable returns, the result of the patch held in the product stage appears after one edge.
- R6: A synchronous active-high `rst_i` clears both stages, giving `dot_o` = 0 and `dot_vld_o` = 0.
- R7: `dot_vld_o` carries the `patch_vld_i` value that was captured with the patch. A patch taken with `patch_vld_i` low gives `dot_vld_o` = 0 two cycles later.
- R8: A patch equal to the weight pattern gives +9 (5'b01001). A patch equal to its bitwise inverse gives -9 (5'b10111).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| mul_en_i | input | 1 | Enable for the product stage |
| sum_en_i | input | 1 | Enable for the sum stage |
| patch_vld_i | input | 1 | The presented patch is valid |
| patch_i | input | 9 | Activation window; bit k is tap k |
| dot_o | output | 5 | Signed dot product, two's complement |
| dot_vld_o | output | 1 | The result on `dot_o` is valid |

## Verification
The properties assume that `rst_i` is held high over the first clock edge. They also assume that the enables and `patch_vld_i` are known values on every edge after reset. The bench drives every input from time zero and changes inputs only on falling edges. It asserts reset for several cycles before any stimulus, so the hold and latency properties always compare against register values that were defined by reset.

// File: rtl/xwd_pkg.sv
package xwd_pkg;

    // Width of a count from 0 to taps inclusive
    function automatic int count_width(input int taps);
        return $clog2(taps + 1);
    endfunction

    // Signed width able to hold -taps .. +taps
    function automatic int dot_width(input int taps);
        return $clog2(taps + 1) + 1;
    endfunction

endpackage

// File: rtl/xwd_product_stage.sv
module xwd_product_stage #(
    parameter int KSIZE = 3,
    parameter int TAPS = KSIZE * KSIZE,
    parameter logic [TAPS-1:0] W_PATTERN = '1
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            en_i,
    input  logic            vld_i,
    input  logic [TAPS-1:0] patch_i,
    output logic [TAPS-1:0] agree_o,
    output logic            vld_o
);

    typedef struct packed {
        logic [TAPS-1:0] agree;
        logic            vld;
    } prod_t;

    prod_t st_d, st_q;
    logic [TAPS-1:0] tap_agree;

    // One sign product per tap: bits that agree give +1
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        assign tap_agree[k] = ~(patch_i[k] ^ W_PATTERN[k]);
    end

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.agree = tap_agree;
            st_d.vld   = vld_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign agree_o = st_q.agree;
    assign vld_o   = st_q.vld;

endmodule

// File: rtl/xwd_adder_tree.sv
module xwd_adder_tree #(
    parameter int KSIZE = 3,
    parameter int TAPS = KSIZE * KSIZE,
    parameter int CNT_W = xwd_pkg::count_width(TAPS)
) (
    input  logic [TAPS-1:0]  agree_i,
    output logic [CNT_W-1:0] count_o
);

    localparam int ROW_W = xwd_pkg::count_width(KSIZE);

    logic [ROW_W-1:0] row_sum [KSIZE];
    logic [CNT_W-1:0] upper_sum;

    // Level 1: one small popcount per kernel row
    for (genvar r = 0; r < KSIZE; r++) begin : g_row
        always_comb begin
            row_sum[r] = '0;
            for (int c = 0; c < KSIZE; c++) begin
                row_sum[r] = row_sum[r] + ROW_W'(agree_i[r*KSIZE + c]);
            end
        end
    end

    // Level 2: merge every row except the last
    always_comb begin
        upper_sum = '0;
        for (int r = 0; r < KSIZE - 1; r++) begin
            upper_sum = upper_sum + CNT_W'(row_sum[r]);
        end
    end

    // Level 3: add the last row
    assign count_o = upper_sum + CNT_W'(row_sum[KSIZE-1]);

endmodule

// File: rtl/xwd_sum_stage.sv
module xwd_sum_stage #(
    parameter int TAPS = 9,
    parameter int CNT_W = xwd_pkg::count_width(TAPS),
    parameter int OUT_W = xwd_pkg::dot_width(TAPS)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             vld_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [OUT_W-1:0] dot_o,
    output logic             vld_o
);

    typedef struct packed {
        logic [OUT_W-1:0] dot;
        logic             vld;
    } sum_t;

    sum_t st_d, st_q;
    logic [OUT_W-1:0] signed_val;

    // Agreements count +1, disagreements count -1: 2*m - TAPS
    always_comb begin
        signed_val = {count_i, 1'b0} - OUT_W'(TAPS);
    end

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.dot = signed_val;
            st_d.vld = vld_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dot_o = st_q.dot;
    assign vld_o = st_q.vld;

endmodule

// File: rtl/xnor_window_dot.sv
module xnor_window_dot #(
    parameter int KSIZE = 3,
    parameter logic [KSIZE*KSIZE-1:0] W_PATTERN = 9'b101100111
) (
    input  logic                                         clk_i,
    input  logic                                         rst_i,
    input  logic                                         mul_en_i,
    input  logic                                         sum_en_i,
    input  logic                                         patch_vld_i,
    input  logic [KSIZE*KSIZE-1:0]                       patch_i,
    output logic [xwd_pkg::dot_width(KSIZE*KSIZE)-1:0]   dot_o,
    output logic                                         dot_vld_o
);

    localparam int TAPS  = KSIZE * KSIZE;
    localparam int CNT_W = xwd_pkg::count_width(TAPS);
    localparam int OUT_W = xwd_pkg::dot_width(TAPS);

    logic [TAPS-1:0]  agree_q;
    logic             prod_vld_q;
    logic [CNT_W-1:0] agree_cnt;

    xwd_product_stage #(
        .KSIZE     (KSIZE),
        .TAPS      (TAPS),
        .W_PATTERN (W_PATTERN)
    ) u_prod (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (mul_en_i),
        .vld_i   (patch_vld_i),
        .patch_i (patch_i),
        .agree_o (agree_q),
        .vld_o   (prod_vld_q)
    );

    xwd_adder_tree #(
        .KSIZE (KSIZE),
        .TAPS  (TAPS),
        .CNT_W (CNT_W)
    ) u_tree (
        .agree_i (agree_q),
        .count_o (agree_cnt)
    );

    xwd_sum_stage #(
        .TAPS  (TAPS),
        .CNT_W (CNT_W),
        .OUT_W (OUT_W)
    ) u_sum (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (sum_en_i),
        .vld_i   (prod_vld_q),
        .count_i (agree_cnt),
        .dot_o   (dot_o),
        .vld_o   (dot_vld_o)
    );

endmodule

// File: rtl/xwd_checker.sv
module xwd_checker #(
    parameter int KSIZE = 3,
    parameter logic [KSIZE*KSIZE-1:0] W_PATTERN = 9'b101100111
) (
    input logic                                       clk_i,
    input logic                                       rst_i,
    input logic                                       mul_en_i,
    input logic                                       sum_en_i,
    input logic                                       patch_vld_i,
    input logic [KSIZE*KSIZE-1:0]                     patch_i,
    input logic [xwd_pkg::dot_width(KSIZE*KSIZE)-1:0] dot_o,
    input logic                                       dot_vld_o
);

    localparam int TAPS  = KSIZE * KSIZE;
    localparam int OUT_W = xwd_pkg::dot_width(TAPS);

    // R1: a valid result lies in -TAPS..+TAPS with the parity of TAPS
    a_r1_range_parity: assert property (@(posedge clk_i) disable iff (rst_i)
        dot_vld_o |-> ($signed(dot_o) <= $signed(OUT_W'(TAPS))
                       && $signed(dot_o) >= -$signed(OUT_W'(TAPS))
                       && dot_o[0] == TAPS[0]));

    // R3: an accepted valid patch followed by a sum enable yields a valid output
    a_r3_latency: assert property (@(posedge clk_i) disable iff (rst_i)
        (patch_vld_i && mul_en_i) ##1 sum_en_i |=> dot_vld_o);

    // R5: the sum stage holds while its enable is low
    a_r5_sum_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !sum_en_i |=> ($stable(dot_o) && $stable(dot_vld_o)));

    // R6: reset clears the output stage
    a_r6_reset_clear: assert property (@(posedge clk_i)
        rst_i |=> (dot_o == '0 && !dot_vld_o));

    // R8: a patch matching every weight gives the top of the range
    a_r8_full_match: assert property (@(posedge clk_i) disable iff (rst_i)
        (patch_vld_i && mul_en_i && patch_i == W_PATTERN) ##1 sum_en_i
        |=> dot_o == OUT_W'(TAPS));

endmodule

bind xnor_window_dot xwd_checker #(
    .KSIZE     (KSIZE),
    .W_PATTERN (W_PATTERN)
) u_xwd_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .mul_en_i    (mul_en_i),
    .sum_en_i    (sum_en_i),
    .patch_vld_i (patch_vld_i),
    .patch_i     (patch_i),
    .dot_o       (dot_o),
    .dot_vld_o   (dot_vld_o)
);

// File: tb/xnor_window_dot_test.sv
module xnor_window_dot_test;

    localparam logic [8:0] WPAT = 9'b101100111;

    logic       clk = 1'b0;
    logic       rst_i = 1'b1;
    logic       mul_en_i = 1'b0;
    logic       sum_en_i = 1'b0;
    logic       patch_vld_i = 1'b0;
    logic [8:0] patch_i = '0;
    logic [4:0] dot_o;
    logic       dot_vld_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    xnor_window_dot #(.KSIZE(3), .W_PATTERN(WPAT)) uut (
        .clk_i       (clk),
        .rst_i       (rst_i),
        .mul_en_i    (mul_en_i),
        .sum_en_i    (sum_en_i),
        .patch_vld_i (patch_vld_i),
        .patch_i     (patch_i),
        .dot_o       (dot_o),
        .dot_vld_o   (dot_vld_o)
    );

    // Expected result from R1: 2*agreements - 9 as 5-bit two's complement
    function automatic logic [4:0] expect_dot(input logic [8:0] p);
        int m;
        m = $countones(~(p ^ WPAT));
        return 5'(2 * m - 9);
    endfunction

    task automatic check(input string req, input logic [4:0] got_dot, input logic got_vld,
                         input logic [4:0] exp_dot, input logic exp_vld);
        checks++;
        if (got_dot !== exp_dot || got_vld !== exp_vld) begin
            errors++;
            $display("FAIL %s: dot=%0d vld=%0b expected dot=%0d vld=%0b", req,
                     $signed(got_dot), got_vld, $signed(exp_dot), exp_vld);
        end
    endtask

    task automatic drive(input logic [8:0] p, input logic v, input logic me, input logic se);
        patch_i = p;
        patch_vld_i = v;
        mul_en_i = me;
        sum_en_i = se;
    endtask

    // Present one patch with both enables, wait until its result is visible
    task automatic run_one(input logic [8:0] p, input logic v);
        @(negedge clk);
        drive(p, v, 1'b1, 1'b1);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R6 reset", dot_o, dot_vld_o, 5'd0, 1'b0);
    endtask

    task automatic t_extremes;
        run_one(WPAT, 1'b1);
        check("R8 all agree", dot_o, dot_vld_o, 5'b01001, 1'b1);
        run_one(~WPAT, 1'b1);
        check("R8 none agree", dot_o, dot_vld_o, 5'b10111, 1'b1);
        run_one(9'b000000000, 1'b1);
        check("R1 zero patch", dot_o, dot_vld_o, expect_dot(9'b000000000), 1'b1);
    endtask

    task automatic t_single_tap;
        for (int k = 0; k < 9; k++) begin
            run_one(WPAT ^ (9'd1 << k), 1'b1);
            check("R2 single tap flip", dot_o, dot_vld_o, 5'd7, 1'b1);
        end
    endtask

    task automatic t_stream;
        logic [8:0] seq [6];
        seq[0] = 9'h0F3; seq[1] = 9'h1AA; seq[2] = 9'h055;
        seq[3] = 9'h167; seq[4] = 9'h198; seq[5] = 9'h013;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i >= 2)
                check("R3 streaming latency", dot_o, dot_vld_o, expect_dot(seq[i-2]), 1'b1);
            if (i < 6) drive(seq[i], 1'b1, 1'b1, 1'b1);
            else       drive(9'h000, 1'b0, 1'b1, 1'b1);
        end
    endtask

    task automatic t_invalid;
        run_one(9'h0AB, 1'b0);
        check("R7 invalid patch", dot_o, dot_vld_o, expect_dot(9'h0AB), 1'b0);
    endtask

    task automatic t_mul_hold;
        logic [8:0] a = 9'h1F0;
        logic [8:0] b = 9'h00F;
        @(negedge clk);
        drive(a, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        drive(b, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("R4 product hold first", dot_o, dot_vld_o, expect_dot(a), 1'b1);
        @(negedge clk);
        check("R4 ignored patch", dot_o, dot_vld_o, expect_dot(a), 1'b1);
    endtask

    task automatic t_sum_hold;
        logic [8:0] x = 9'h167;
        logic [8:0] y = 9'h0C3;
        run_one(x, 1'b1);
        drive(y, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check("R5 sum hold", dot_o, dot_vld_o, expect_dot(x), 1'b1);
        drive(y, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("R5 sum resume", dot_o, dot_vld_o, expect_dot(y), 1'b0);
    endtask

    task automatic t_reset_mid;
        run_one(WPAT, 1'b1);
        @(negedge clk);
        rst_i = 1'b1;
        @(negedge clk);
        rst_i = 1'b0;
        check("R6 reset clears result", dot_o, dot_vld_o, 5'd0, 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_i = 1'b0;
        t_reset();
        t_extremes();
        t_single_tap();
        t_stream();
        t_invalid();
        t_mul_hold();
        t_sum_hold();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule